// File: doc/BRIEF.md
# Open-Page DRAM Bank Command Sequencer

This block sits between a cache and a set of memory devices. It takes one cache-block request at a time, either a read or a write, each carrying a 31-bit physical byte address. It splits the address into row, bank and column fields and checks the target bank against a per-bank record of the currently open row. It then emits the shortest command sequence that reaches the data, and moves the 64-byte block as eight column transfers on a 64-bit path.

There are three access cases. A row already open in the target bank needs only column commands. An idle, precharged bank needs an activate first. A different open row needs a precharge, then an activate, then the column commands. Two gaps are set by static inputs: the gap from precharge to activate and the gap from activate to the first column command. A static input picks how bank bits are placed in the address, and another static input folds row bits into the bank index to spread conflicts. Each request ends with a one-cycle completion pulse that reports which of the three cases occurred.

Top module: `bank_cmd_seq`

## Requirements
- R1: After reset `reqReady` is 1, `cmdOp` is 0 (no command), `doneValid` is 0, and every bank is precharged, so the first access to any bank is classed as a miss.
- R2: With `cfgBlockIlv`=0, the address reads as row = bits 30:17, bank = bits 16:14, column = bits 13:3. The upper eight column bits are taken from address bits 13:6.
- R3: With `cfgBlockIlv`=1, the address reads as row = bits 30:17, upper column = bits 16:9, bank = bits 8:6, low column = bits 5:3. Consecutive 64-byte blocks therefore fall in consecutive banks.
- R4: With `cfgHashEn`=1, the bank index is the decoded bank field XORed with row bits 2:0.
- R5: A row hit issues no activate and no precharge. The first column command appears in the cycle after acceptance.
- R6: A request to a precharged bank issues an activate (`cmdOp`=1) in the cycle after acceptance. The first column command follows max(`cfgTrcd`,1) cycles later.
- R7: A request to a bank holding another row issues a precharge (`cmdOp`=2) in the cycle after acceptance. An activate follows max(`cfgTrp`,1) cycles later, and the first column command max(`cfgTrcd`,1) cycles after that. The activated row becomes the open row of that bank.
- R8: Column commands come on eight consecutive cycles with `cmdOp`=3 for read and 4 for write. Beat k carries column {upper column, k} and `beatIdx`=k, with `beatValid` high. No-command cycles show `cmdOp`=0.
- R9: During write beats `devWrData` equals `wrData`. During read beats `rdData` equals `devRdData`. At all other times both are zero.
- R10: `doneValid` pulses for one cycle, on the cycle of beat 7. In that cycle `doneClass` is 0 for a hit, 1 for a precharged bank and 2 for a conflict.
- R11: `reqReady` is low from the cycle after acceptance through the final beat, and high again in the next cycle.
- R12: A gap setting of 0 acts as a gap of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgBlockIlv | input | 1 | Address map: 0 row-interleaved, 1 block-interleaved |
| cfgHashEn | input | 1 | Fold row bits 2:0 into the bank index |
| cfgTrp | input | 4 | Cycles from precharge to activate |
| cfgTrcd | input | 4 | Cycles from activate to first column command |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Sequencer idle and accepting |
| reqWrite | input | 1 | 1 write, 0 read |
| reqAddr | input | 31 | Physical byte address |
| cmdOp | output | 3 | 0 none, 1 activate, 2 precharge, 3 read, 4 write |
| cmdBank | output | 3 | Bank of the command |
| cmdRow | output | 14 | Row of the command |
| cmdCol | output | 11 | Column of the command |
| beatValid | output | 1 | A data beat transfers this cycle |
| beatIdx | output | 3 | Beat number within the block |
| wrData | input | 64 | Write beat from the requester |
| devWrData | output | 64 | Write beat toward the devices |
| devRdData | input | 64 | Read beat from the devices |
| rdData | output | 64 | Read beat toward the requester |
| doneValid | output | 1 | Block complete |
| doneClass | output | 2 | 0 hit, 1 miss, 2 conflict |

## Verification
Counting from the clock edge that accepts a request, the first command is due one cycle later. For a miss the first column command is due one cycle plus the activate gap after acceptance. For a conflict it is due one cycle plus both gaps. The last beat and the completion pulse come seven cycles after the first column command, and ready returns one cycle after that. The bench turns each request into this per-cycle list of expected commands, beats and flags, computed from its own model of the open rows. It compares the list against the outputs at every falling edge from acceptance to completion.

// File: rtl/bank_seq_pkg.sv
package bank_seq_pkg;
  localparam int ROW_W   = 14;
  localparam int BANK_W  = 3;
  localparam int COL_W   = 11;
  localparam int BYTE_W  = 3;
  localparam int BEAT_W  = 3;
  localparam int ADDR_W  = ROW_W + BANK_W + COL_W + BYTE_W;
  localparam int NBANK   = 1 << BANK_W;
  localparam int NBEAT   = 1 << BEAT_W;
  localparam int COLHI_W = COL_W - BEAT_W;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0, OP_ACT = 3'd1, OP_PRE = 3'd2, OP_RD = 3'd3, OP_WR = 3'd4
  } cmd_op_e;

  typedef enum logic [1:0] {
    CLS_HIT = 2'd0, CLS_MISS = 2'd1, CLS_CONFLICT = 2'd2
  } req_cls_e;

  typedef struct packed {
    logic capture;
    logic doAct;
    logic doPre;
    logic doCol;
    logic loadRp;
    logic loadRcd;
    logic cntDec;
  } seq_strobe_t;
endpackage

// File: rtl/bank_seq_dp.sv
module bank_seq_dp
  import bank_seq_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  seq_strobe_t         strb,
  input  logic                cfgBlockIlv,
  input  logic                cfgHashEn,
  input  logic [CNT_W-1:0]    cfgTrp,
  input  logic [CNT_W-1:0]    cfgTrcd,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqWrite,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [DATA_W-1:0]   devRdData,
  output logic                rowHit,
  output logic                bankOpen,
  output logic                cntZero,
  output logic                beatLast,
  output logic                isWrite,
  output logic [BANK_W-1:0]   cmdBank,
  output logic [ROW_W-1:0]    cmdRow,
  output logic [COL_W-1:0]    cmdCol,
  output logic [BEAT_W-1:0]   beatIdx,
  output logic [DATA_W-1:0]   devWrData,
  output logic [DATA_W-1:0]   rdData
);
  localparam int BANK_LO_ROW = BYTE_W + COL_W;
  localparam int BANK_LO_BLK = BYTE_W + BEAT_W;
  localparam int COLHI_LO_ROW = BYTE_W + BEAT_W;
  localparam int COLHI_LO_BLK = BYTE_W + BEAT_W + BANK_W;

  logic [ROW_W-1:0]   decRow;
  logic [BANK_W-1:0]  decBank;
  logic [COLHI_W-1:0] decColHi;

  always_comb begin
    decRow = reqAddr[ADDR_W-1 -: ROW_W];
    if (cfgBlockIlv) begin
      decBank  = reqAddr[BANK_LO_BLK +: BANK_W];
      decColHi = reqAddr[COLHI_LO_BLK +: COLHI_W];
    end else begin
      decBank  = reqAddr[BANK_LO_ROW +: BANK_W];
      decColHi = reqAddr[COLHI_LO_ROW +: COLHI_W];
    end
    if (cfgHashEn) decBank = decBank ^ decRow[BANK_W-1:0];
  end

  logic [ROW_W-1:0]   latRow;
  logic [BANK_W-1:0]  latBank;
  logic [COLHI_W-1:0] latColHi;
  logic               latWrite;
  logic [BEAT_W-1:0]  beatQ;
  logic [CNT_W-1:0]   gapCnt;
  logic [NBANK-1:0]   openVld;
  logic [ROW_W-1:0]   openRow [NBANK];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latRow <= '0; latBank <= '0; latColHi <= '0; latWrite <= 1'b0;
      beatQ <= '0;
    end else if (strb.capture) begin
      latRow <= decRow; latBank <= decBank; latColHi <= decColHi;
      latWrite <= reqWrite; beatQ <= '0;
    end else if (strb.doCol) begin
      beatQ <= beatQ + BEAT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) gapCnt <= '0;
    else if (strb.loadRp) gapCnt <= (cfgTrp == '0) ? '0 : cfgTrp - CNT_W'(1);
    else if (strb.loadRcd) gapCnt <= (cfgTrcd == '0) ? '0 : cfgTrcd - CNT_W'(1);
    else if (strb.cntDec && gapCnt != '0) gapCnt <= gapCnt - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      openVld <= '0;
      for (int b = 0; b < NBANK; b++) openRow[b] <= '0;
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        if (latBank == BANK_W'(b)) begin
          if (strb.doAct) begin
            openVld[b] <= 1'b1;
            openRow[b] <= latRow;
          end else if (strb.doPre) begin
            openVld[b] <= 1'b0;
          end
        end
      end
    end
  end

  assign bankOpen  = openVld[latBank];
  assign rowHit    = openVld[latBank] && (openRow[latBank] == latRow);
  assign cntZero   = (gapCnt == '0);
  assign beatLast  = (beatQ == BEAT_W'(NBEAT - 1));
  assign isWrite   = latWrite;
  assign cmdBank   = latBank;
  assign cmdRow    = latRow;
  assign cmdCol    = {latColHi, beatQ};
  assign beatIdx   = beatQ;
  assign devWrData = (strb.doCol && latWrite)  ? wrData    : '0;
  assign rdData    = (strb.doCol && !latWrite) ? devRdData : '0;
endmodule

// File: rtl/bank_seq_ctrl.sv
module bank_seq_ctrl
  import bank_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        rowHit,
  input  logic        bankOpen,
  input  logic        cntZero,
  input  logic        beatLast,
  input  logic        isWrite,
  output seq_strobe_t strb,
  output logic        reqReady,
  output cmd_op_e     cmdOp,
  output logic        doneValid,
  output req_cls_e    doneClass
);
  typedef enum logic [2:0] {ST_IDLE, ST_LOOK, ST_PREW, ST_ACTW, ST_COL} seq_state_e;

  seq_state_e stateQ, stateD;
  req_cls_e   clsQ, clsD;
  cmd_op_e    colOp;

  assign colOp = isWrite ? OP_WR : OP_RD;

  always_comb begin
    strb   = '0;
    cmdOp  = OP_NOP;
    stateD = stateQ;
    clsD   = clsQ;
    case (stateQ)
      ST_IDLE: if (reqValid) begin
        strb.capture = 1'b1;
        stateD = ST_LOOK;
      end
      ST_LOOK: begin
        if (rowHit) begin
          strb.doCol = 1'b1; cmdOp = colOp; clsD = CLS_HIT; stateD = ST_COL;
        end else if (bankOpen) begin
          strb.doPre = 1'b1; strb.loadRp = 1'b1; cmdOp = OP_PRE;
          clsD = CLS_CONFLICT; stateD = ST_PREW;
        end else begin
          strb.doAct = 1'b1; strb.loadRcd = 1'b1; cmdOp = OP_ACT;
          clsD = CLS_MISS; stateD = ST_ACTW;
        end
      end
      ST_PREW: if (cntZero) begin
        strb.doAct = 1'b1; strb.loadRcd = 1'b1; cmdOp = OP_ACT; stateD = ST_ACTW;
      end else strb.cntDec = 1'b1;
      ST_ACTW: if (cntZero) begin
        strb.doCol = 1'b1; cmdOp = colOp; stateD = ST_COL;
      end else strb.cntDec = 1'b1;
      ST_COL: begin
        strb.doCol = 1'b1; cmdOp = colOp;
        if (beatLast) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      clsQ   <= CLS_HIT;
    end else begin
      stateQ <= stateD;
      clsQ   <= clsD;
    end
  end

  assign reqReady  = (stateQ == ST_IDLE);
  assign doneValid = (stateQ == ST_COL) && beatLast;
  assign doneClass = clsQ;
endmodule

// File: rtl/bank_cmd_seq.sv
module bank_cmd_seq
  import bank_seq_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgBlockIlv,
  input  logic                cfgHashEn,
  input  logic [CNT_W-1:0]    cfgTrp,
  input  logic [CNT_W-1:0]    cfgTrcd,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  output logic [2:0]          cmdOp,
  output logic [BANK_W-1:0]   cmdBank,
  output logic [ROW_W-1:0]    cmdRow,
  output logic [COL_W-1:0]    cmdCol,
  output logic                beatValid,
  output logic [BEAT_W-1:0]   beatIdx,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   devWrData,
  input  logic [DATA_W-1:0]   devRdData,
  output logic [DATA_W-1:0]   rdData,
  output logic                doneValid,
  output logic [1:0]          doneClass
);
  seq_strobe_t strb;
  cmd_op_e     opE;
  req_cls_e    clsE;
  logic rowHit, bankOpen, cntZero, beatLast, isWrite;

  bank_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .rowHit(rowHit),
    .bankOpen(bankOpen), .cntZero(cntZero), .beatLast(beatLast),
    .isWrite(isWrite), .strb(strb), .reqReady(reqReady), .cmdOp(opE),
    .doneValid(doneValid), .doneClass(clsE)
  );

  bank_seq_dp #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgBlockIlv(cfgBlockIlv),
    .cfgHashEn(cfgHashEn), .cfgTrp(cfgTrp), .cfgTrcd(cfgTrcd),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .wrData(wrData),
    .devRdData(devRdData), .rowHit(rowHit), .bankOpen(bankOpen),
    .cntZero(cntZero), .beatLast(beatLast), .isWrite(isWrite),
    .cmdBank(cmdBank), .cmdRow(cmdRow), .cmdCol(cmdCol), .beatIdx(beatIdx),
    .devWrData(devWrData), .rdData(rdData)
  );

  assign cmdOp     = opE;
  assign doneClass = clsE;
  assign beatValid = strb.doCol;
endmodule

// File: rtl/bank_cmd_seq_chk.sv
module bank_cmd_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic [2:0]  cmdOp,
  input logic        beatValid,
  input logic [2:0]  beatIdx,
  input logic        doneValid,
  input logic [63:0] devWrData,
  input logic [63:0] rdData
);
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && beatIdx != 3'd7) |=> (beatValid && beatIdx == 3'($past(beatIdx) + 3'd1))); // R8
  AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (beatValid && beatIdx == 3'd7)); // R10
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R11
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> reqReady); // R11
  AST_PRE_THEN_ACT: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == 3'd2) |=> (cmdOp == 3'd0 || cmdOp == 3'd1)); // R7
  AST_DATA_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !beatValid |-> (devWrData == '0 && rdData == '0)); // R9
endmodule

bind bank_cmd_seq bank_cmd_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .cmdOp(cmdOp), .beatValid(beatValid), .beatIdx(beatIdx),
  .doneValid(doneValid), .devWrData(devWrData), .rdData(rdData)
);

// File: tb/bank_cmd_seq_bench.sv
`timescale 1ns/1ps
module bank_cmd_seq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgBlockIlv = 1'b0, cfgHashEn = 1'b0;
  logic [3:0]  cfgTrp = 4'd3, cfgTrcd = 4'd2;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [30:0] reqAddr = '0;
  logic [63:0] wrData = '0, devRdData = '0;
  logic        reqReady, beatValid, doneValid;
  logic [2:0]  cmdOp, cmdBank, beatIdx;
  logic [13:0] cmdRow;
  logic [10:0] cmdCol;
  logic [63:0] devWrData, rdData;
  logic [1:0]  doneClass;

  int nChecks = 0;
  int nErrors = 0;
  int openRow [8];

  always #2 clk = ~clk;

  bank_cmd_seq u_bank_cmd_seq (
    .clk(clk), .rstN(rstN), .cfgBlockIlv(cfgBlockIlv), .cfgHashEn(cfgHashEn),
    .cfgTrp(cfgTrp), .cfgTrcd(cfgTrcd), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .cmdOp(cmdOp), .cmdBank(cmdBank),
    .cmdRow(cmdRow), .cmdCol(cmdCol), .beatValid(beatValid), .beatIdx(beatIdx),
    .wrData(wrData), .devWrData(devWrData), .devRdData(devRdData), .rdData(rdData),
    .doneValid(doneValid), .doneClass(doneClass)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void decode(input logic [30:0] a, output int bank,
                                 output int row, output int colHi);
    row = int'(a[30:17]);
    if (cfgBlockIlv) begin bank = int'(a[8:6]);   colHi = int'(a[16:9]); end
    else             begin bank = int'(a[16:14]); colHi = int'(a[13:6]); end
    if (cfgHashEn) bank = bank ^ (row & 7);
  endfunction

  // decTag names the requirement covering the address decode of this request
  task automatic doReq(bit wr, logic [30:0] a, int expBank, string decTag);
    int bank, row, colHi, cls, gp, gc, firstCol, last, expOp;
    string clsTag;
    decode(a, bank, row, colHi);
    chk({decTag, " model bank"}, 64'(bank), 64'(expBank));
    cls = (openRow[bank] == row) ? 0 : (openRow[bank] < 0 ? 1 : 2);
    clsTag = (cls == 0) ? "R5" : (cls == 1 ? "R6" : "R7");
    gp = (cfgTrp == 0) ? 1 : int'(cfgTrp);
    gc = (cfgTrcd == 0) ? 1 : int'(cfgTrcd);
    firstCol = (cls == 0) ? 1 : (cls == 1 ? 1 + gc : 1 + gp + gc);
    last = firstCol + 7;
    @(negedge clk);
    chk("R11 ready while idle", 64'(reqReady), 64'd1);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a;
    wrData = {a, 33'h1_2345_6789}; devRdData = ~{33'h0_5A5A_A5A5, a};
    @(posedge clk);
    for (int k = 1; k <= last; k++) begin
      @(negedge clk);
      reqValid = 1'b0;
      if (k >= firstCol) expOp = wr ? 4 : 3;
      else if (cls == 2 && k == 1) expOp = 2;
      else if ((cls == 1 && k == 1) || (cls == 2 && k == 1 + gp)) expOp = 1;
      else expOp = 0;
      chk({clsTag, " command op"}, 64'(cmdOp), 64'(expOp));
      chk("R11 ready low while busy", 64'(reqReady), 64'd0);
      if (expOp != 0) begin
        chk({decTag, " command bank"}, 64'(cmdBank), 64'(bank));
        chk({decTag, " command row"}, 64'(cmdRow), 64'(row));
      end
      if (k >= firstCol) begin
        chk("R8 column", 64'(cmdCol), 64'(colHi * 8 + (k - firstCol)));
        chk("R8 beat index", 64'(beatIdx), 64'(k - firstCol));
        chk("R8 beat valid", 64'(beatValid), 64'd1);
        chk("R9 write path", devWrData, wr ? wrData : 64'd0);
        chk("R9 read path", rdData, wr ? 64'd0 : devRdData);
      end else begin
        chk("R8 beat idle", 64'(beatValid), 64'd0);
        chk("R9 data idle", devWrData | rdData, 64'd0);
      end
      chk("R10 done pulse", 64'(doneValid), 64'(k == last));
      if (k == last) chk("R10 class", 64'(doneClass), 64'(cls));
    end
    openRow[bank] = row;
  endtask

  function automatic logic [30:0] mk(int row, int bank, int col);
    return cfgBlockIlv ? {14'(row), 8'(col >> 3), 3'(bank), 3'(col), 3'b0}
                       : {14'(row), 3'(bank), 11'(col), 3'b0};
  endfunction

  initial begin
    #400000;
    nChecks++; nErrors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    for (int b = 0; b < 8; b++) openRow[b] = -1;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 64'(reqReady), 64'd1);
    chk("R1 no command after reset", 64'(cmdOp), 64'd0);
    chk("R1 no done after reset", 64'(doneValid), 64'd0);

    // R2 row-interleaved map
    doReq(1'b0, mk(100, 5, 40), 5, "R2");    // R1 closed bank -> miss
    doReq(1'b0, mk(100, 5, 200), 5, "R2");   // R5 hit
    doReq(1'b1, mk(33, 5, 8), 5, "R2");      // R7 conflict
    doReq(1'b0, mk(33, 5, 1000), 5, "R2");   // R7 new row now open -> hit
    doReq(1'b0, mk(100, 5, 0), 5, "R2");     // conflict back
    doReq(1'b1, mk(7, 2, 2047), 2, "R2");    // miss on other bank

    // R3 block-interleaved: consecutive blocks in consecutive banks
    cfgBlockIlv = 1'b1;
    for (int n = 0; n < 8; n++)
      doReq(n[0], 31'((9 << 17) + 64 * n), n, "R3");
    doReq(1'b0, 31'((9 << 17) + 64 * 8), 0, "R3"); // wraps to bank 0, hit

    // R4 bank hashing
    cfgHashEn = 1'b1;
    doReq(1'b0, mk(13, 1, 64), 1 ^ 5, "R4");
    doReq(1'b1, mk(6, 3, 16), 3 ^ 6, "R4");
    cfgBlockIlv = 1'b0;
    doReq(1'b0, mk(15, 7, 24), 7 ^ 7, "R4");

    // R12 zero gaps
    cfgHashEn = 1'b0; cfgTrp = 4'd0; cfgTrcd = 4'd0;
    doReq(1'b0, mk(200, 4, 80), 4, "R12");
    doReq(1'b1, mk(201, 4, 88), 4, "R12");
    cfgTrp = 4'd5; cfgTrcd = 4'd7;
    doReq(1'b0, mk(202, 4, 96), 4, "R7");

    @(negedge clk);
    chk("R11 ready after last request", 64'(reqReady), 64'd1);
    chk("R8 idle op", 64'(cmdOp), 64'd0);
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule